// File: doc/BRIEF.md
# Basic Block Hash Verifier

This block watches the stream of instructions that a 32-bit RISC-V core retires and cuts it into basic blocks. Every word of a block is folded into a running 32-bit hash. When the instruction that closes the block retires, the block's final hash is cut down to a configured width and compared against a reference digest. The reference is fetched from a small table that software preloads through a write port; each entry is keyed by the address of the block's first instruction.

A matching digest produces a one-cycle pass pulse. A differing digest, or a block whose start address has no table entry, produces a one-cycle fail pulse. It also sets a violation flag that stays high until reset. The compare takes one extra cycle, so the block asks the core to stall for exactly that cycle after each block end. The core must hold any retirement offered during that cycle and present it again afterwards.

Top module: `bb_hash_verifier`

## Requirements
- R1: After a synchronous active-low reset, chk_pass, chk_fail, violation and stall are low, and every table entry is empty, so no start address finds a digest.
- R2: A retired instruction closes the current block in any of these cases: its opcode field (bits 6:0) is 1100011 and its funct3 field (bits 14:12) is one of 000, 001, 100, 101, 110 or 111; its opcode is 1101111; its opcode is 1100111, which includes the return encoding 0x00008067; or ret_fn_last is high with it.
- R3: Any other instruction continues the current block. This includes opcode 1100011 with funct3 010 or 011.
- R4: The first accepted instruction after reset, and the first after any block end, starts a new block. Its PC becomes the block's start address, and the running hash restarts from the seed parameter.
- R5: Each accepted instruction word w updates the hash h as follows: x = rotl(h,5) XOR w, then x ^= x>>13, then x += x<<3, then x ^= x>>7. The block hash is the value after its closing instruction.
- R6: Only the low HASH_W bits of the block hash are compared with the HASH_W-bit table digest. A difference in any of those bits, including the top one, counts as a mismatch.
- R7: A retirement is accepted when ret_valid is high and stall is low. In the cycle after a block end is accepted, stall is high and any retirement offered is ignored. The result pulse appears in the cycle after that.
- R8: If the lookup finds a digest equal to the truncated hash, chk_pass pulses for one cycle and chk_fail stays low.
- R9: On a digest mismatch, chk_fail pulses for one cycle and violation rises and stays high until reset.
- R10: If no valid table entry holds the block's start address, the result is a fail with violation set, as in R9.
- R11: A write with tbl_we high loads entry tbl_idx with tbl_pc and tbl_hash from the next cycle on, replacing earlier contents. When several entries hold the same address, the lowest index is used.
- R12: Cycles with ret_valid low leave the block, its hash and the outputs unchanged, so gaps inside a block do not alter its result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ret_valid | input | 1 | A retired instruction is offered this cycle |
| ret_pc | input | 32 | Address of the offered instruction |
| ret_instr | input | 32 | Instruction word of the offered instruction |
| ret_fn_last | input | 1 | Offered instruction is the last one of its function |
| tbl_we | input | 1 | Table write strobe |
| tbl_idx | input | $clog2(DEPTH) | Table entry to write |
| tbl_pc | input | 32 | Block start address stored in the entry |
| tbl_hash | input | HASH_W | Expected truncated digest stored in the entry |
| chk_pass | output | 1 | One-cycle pulse: block digest matched |
| chk_fail | output | 1 | One-cycle pulse: block digest mismatched or missing |
| violation | output | 1 | Sticky integrity-violation flag |
| stall | output | 1 | Hold retirement; a compare is pending |

## Verification
A wrong block boundary or a stale running hash stays hidden until the next block end. It then shows as a pass or fail pulse one cycle early or late, or as a fail where a pass was due. The bench therefore pairs every block with its own table digest and compares all four outputs against a behavioural model on every cycle, so a slip appears within two cycles of the closing instruction. Table priority and clearing are exposed only through lookups, so the bench writes duplicate and overwritten entries and reruns a block after reset.

// File: rtl/bbv_pkg.sv
// Package: shared types and the hash step for the basic block verifier.
// Assumes 32-bit instruction words (no compressed encodings).
package bbv_pkg;

    localparam logic [6:0] OPC_BRANCH = 7'b1100011;
    localparam logic [6:0] OPC_JAL    = 7'b1101111;
    localparam logic [6:0] OPC_JALR   = 7'b1100111;

    // Classification of a retired instruction by its control effect.
    typedef enum logic [1:0] {
        CT_PLAIN  = 2'd0,
        CT_BRANCH = 2'd1,
        CT_JUMP   = 2'd2,
        CT_INDIR  = 2'd3
    } ctrl_kind_t;

    // One hash step: rotate, fold in the word, then shift/add mixing.
    function automatic logic [31:0] hash_step(input logic [31:0] h, input logic [31:0] w);
        logic [31:0] x;
        x = {h[26:0], h[31:27]} ^ w;
        x = x ^ (x >> 13);
        x = x + (x << 3);
        x = x ^ (x >> 7);
        return x;
    endfunction

endpackage

// File: rtl/bbv_decode.sv
// Module: bbv_decode
// Classifies a retired instruction and says whether it closes a basic block.
// Assumes: full 32-bit encodings; funct3 010/011 under the branch opcode are
// not branches and therefore do not end a block.
module bbv_decode
    import bbv_pkg::*;
(
    input  logic [31:0] instr,
    input  logic        fn_last,
    output logic        blk_end
);

    ctrl_kind_t kind;
    logic [6:0] opc;
    logic [2:0] f3;

    assign opc = instr[6:0];
    assign f3  = instr[14:12];

    // Map opcode and funct3 onto a control-transfer class.
    always_comb begin
        kind = CT_PLAIN;
        unique case (opc)
            OPC_BRANCH: kind = (f3 == 3'b010 || f3 == 3'b011) ? CT_PLAIN : CT_BRANCH;
            OPC_JAL:    kind = CT_JUMP;
            OPC_JALR:   kind = CT_INDIR;
            default:    kind = CT_PLAIN;
        endcase
    end

    // Any transfer or the function-boundary hint closes the block.
    assign blk_end = (kind != CT_PLAIN) || fn_last;

endmodule

// File: rtl/bbv_hash_acc.sv
// Module: bbv_hash_acc
// Tracks the open basic block: start address and running hash. On a block
// end it latches the final hash and start address for one compare cycle.
// Assumes: accept is never high while pend is high (the top gates it).
module bbv_hash_acc
    import bbv_pkg::*;
#(
    parameter logic [31:0] SEED = 32'h5A17C3E1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        accept,
    input  logic        blk_end,
    input  logic [31:0] pc,
    input  logic [31:0] instr,
    output logic        pend,
    output logic [31:0] pend_hash,
    output logic [31:0] pend_pc
);

    logic        in_blk;
    logic [31:0] run_h;
    logic [31:0] blk_pc;
    logic [31:0] h_base;
    logic [31:0] h_nxt;
    logic [31:0] start_pc;

    // Pick seed or running state, and the block's start address.
    always_comb begin
        h_base   = in_blk ? run_h  : SEED;
        start_pc = in_blk ? blk_pc : pc;
        h_nxt    = hash_step(h_base, instr);
    end

    // Advance the block state on each accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_blk    <= 1'b0;
            run_h     <= SEED;
            blk_pc    <= '0;
            pend      <= 1'b0;
            pend_hash <= '0;
            pend_pc   <= '0;
        end else begin
            pend <= accept && blk_end;
            if (accept) begin
                if (blk_end) begin
                    pend_hash <= h_nxt;
                    pend_pc   <= start_pc;
                    in_blk    <= 1'b0;
                end else begin
                    run_h  <= h_nxt;
                    blk_pc <= start_pc;
                    in_blk <= 1'b1;
                end
            end
        end
    end

    // R7: a latched compare is never followed by another in the next cycle
    pend_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend |=> !pend);

endmodule

// File: rtl/bbv_table.sv
// Module: bbv_table
// Expected-digest table keyed by block start address, fully associative.
// Assumes: writes and lookups of the same entry do not coincide; a lookup
// sees the contents as of the start of the cycle. Lowest index wins.
module bbv_table #(
    parameter int DEPTH  = 16,
    parameter int HASH_W = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [31:0]       wr_pc,
    input  logic [HASH_W-1:0] wr_hash,
    input  logic [31:0]       lk_pc,
    output logic              lk_hit,
    output logic [HASH_W-1:0] lk_hash
);

    logic              vld [DEPTH];
    logic [31:0]       tag [DEPTH];
    logic [HASH_W-1:0] dig [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
        // Load this entry when addressed by the write port.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld[i] <= 1'b0;
                tag[i] <= '0;
                dig[i] <= '0;
            end else if (wr_en && wr_idx == MY_IDX) begin
                vld[i] <= 1'b1;
                tag[i] <= wr_pc;
                dig[i] <= wr_hash;
            end
        end
    end

    // Priority search, scanned downward so the lowest matching index wins.
    always_comb begin
        lk_hit  = 1'b0;
        lk_hash = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (vld[i] && tag[i] == lk_pc) begin
                lk_hit  = 1'b1;
                lk_hash = dig[i];
            end
        end
    end

endmodule

// File: rtl/bb_hash_verifier.sv
// Module: bb_hash_verifier (top)
// Splits the retired instruction stream into basic blocks, hashes each
// block and checks the truncated hash against a preloaded table.
// Assumes: the core holds an offered retirement while stall is high.
module bb_hash_verifier
    import bbv_pkg::*;
#(
    parameter int          HASH_W = 16,
    parameter int          DEPTH  = 16,
    parameter logic [31:0] SEED   = 32'h5A17C3E1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ret_valid,
    input  logic [31:0]               ret_pc,
    input  logic [31:0]               ret_instr,
    input  logic                      ret_fn_last,
    input  logic                      tbl_we,
    input  logic [$clog2(DEPTH)-1:0]  tbl_idx,
    input  logic [31:0]               tbl_pc,
    input  logic [HASH_W-1:0]         tbl_hash,
    output logic                      chk_pass,
    output logic                      chk_fail,
    output logic                      violation,
    output logic                      stall
);

    logic              blk_end;
    logic              accept;
    logic              pend;
    logic [31:0]       pend_hash;
    logic [31:0]       pend_pc;
    logic              lk_hit;
    logic [HASH_W-1:0] lk_hash;
    logic              good;

    // Retirements are taken only when no compare is pending.
    assign stall  = pend;
    assign accept = ret_valid && !pend;

    bbv_decode u_dec (
        .instr   (ret_instr),
        .fn_last (ret_fn_last),
        .blk_end (blk_end)
    );

    bbv_hash_acc #(.SEED(SEED)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .blk_end   (blk_end),
        .pc        (ret_pc),
        .instr     (ret_instr),
        .pend      (pend),
        .pend_hash (pend_hash),
        .pend_pc   (pend_pc)
    );

    bbv_table #(.DEPTH(DEPTH), .HASH_W(HASH_W)) u_tab (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_we),
        .wr_idx  (tbl_idx),
        .wr_pc   (tbl_pc),
        .wr_hash (tbl_hash),
        .lk_pc   (pend_pc),
        .lk_hit  (lk_hit),
        .lk_hash (lk_hash)
    );

    // Compare only the configured low bits of the block hash.
    assign good = lk_hit && (lk_hash == pend_hash[HASH_W-1:0]);

    // Register the verdict and hold the violation flag until reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chk_pass  <= 1'b0;
            chk_fail  <= 1'b0;
            violation <= 1'b0;
        end else begin
            chk_pass <= pend && good;
            chk_fail <= pend && !good;
            if (pend && !good) violation <= 1'b1;
        end
    end

    // R7
    stall_then_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> (chk_pass || chk_fail));

    // R7
    result_after_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_pass || chk_fail) |-> $past(stall));

    // R8
    verdict_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(chk_pass && chk_fail));

    // R9
    viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        violation |=> violation);

    // R9
    fail_flags_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chk_fail |-> violation);

endmodule

// File: tb/bb_hash_verifier_test.sv
module bb_hash_verifier_test;

    localparam int          HW   = 16;
    localparam int          DEP  = 16;
    localparam logic [31:0] SEED = 32'h5A17C3E1;

    localparam logic [31:0] I_ADDI = 32'h00108093;
    localparam logic [31:0] I_NOP  = 32'h00000013;
    localparam logic [31:0] I_LW   = 32'h00002003;
    localparam logic [31:0] I_BEQ  = 32'h00000063;
    localparam logic [31:0] I_BNE  = 32'h00001063;
    localparam logic [31:0] I_BLT  = 32'h00004063;
    localparam logic [31:0] I_BGE  = 32'h00005063;
    localparam logic [31:0] I_BLTU = 32'h00006063;
    localparam logic [31:0] I_BGEU = 32'h00007063;
    localparam logic [31:0] I_B010 = 32'h00002063;
    localparam logic [31:0] I_B011 = 32'h00003063;
    localparam logic [31:0] I_JAL  = 32'h000000EF;
    localparam logic [31:0] I_JALR = 32'h000000E7;
    localparam logic [31:0] I_RET  = 32'h00008067;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ret_valid = 1'b0;
    logic [31:0] ret_pc = '0;
    logic [31:0] ret_instr = '0;
    logic ret_fn_last = 1'b0;
    logic tbl_we = 1'b0;
    logic [3:0] tbl_idx = '0;
    logic [31:0] tbl_pc = '0;
    logic [HW-1:0] tbl_hash = '0;
    logic chk_pass, chk_fail, violation, stall;

    always #2.5 clk = ~clk;

    bb_hash_verifier #(.HASH_W(HW), .DEPTH(DEP), .SEED(SEED)) uut (
        .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_pc(ret_pc),
        .ret_instr(ret_instr), .ret_fn_last(ret_fn_last), .tbl_we(tbl_we),
        .tbl_idx(tbl_idx), .tbl_pc(tbl_pc), .tbl_hash(tbl_hash),
        .chk_pass(chk_pass), .chk_fail(chk_fail), .violation(violation),
        .stall(stall)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit chk_en = 0;
    bit done = 0;
    string cur_req = "R1";
    logic [31:0] prog [8];

    // ---------------- behavioural reference ----------------
    function automatic logic [31:0] ref_step(logic [31:0] h, logic [31:0] w);
        logic [31:0] x;
        x = ((h << 5) | (h >> 27)) ^ w;
        x = x ^ (x >> 13);
        x = x + (x << 3);
        x = x ^ (x >> 7);
        return x;
    endfunction

    function automatic bit ref_end(logic [31:0] w, bit fe);
        if (fe) return 1;
        if (w[6:0] == 7'h63) return !(w[14:12] == 3'b010 || w[14:12] == 3'b011);
        if (w[6:0] == 7'h6F || w[6:0] == 7'h67) return 1;
        return 0;
    endfunction

    function automatic logic [HW-1:0] blk_hash(int n);
        logic [31:0] h = SEED;
        for (int i = 0; i < n; i++) h = ref_step(h, prog[i]);
        return h[HW-1:0];
    endfunction

    bit          mt_v [DEP];
    logic [31:0] mt_pc [DEP];
    logic [HW-1:0] mt_h [DEP];
    bit m_open, m_stall, m_pass, m_fail, m_viol;
    logic [31:0] m_h, m_pc, m_cmp_h, m_cmp_pc;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_open <= 0; m_stall <= 0; m_pass <= 0; m_fail <= 0; m_viol <= 0;
            for (int i = 0; i < DEP; i++) mt_v[i] <= 0;
        end else begin
            bit found;
            logic [HW-1:0] d;
            logic [31:0] h0, hn, p0;
            found = 0; d = '0;
            for (int i = 0; i < DEP; i++)
                if (!found && mt_v[i] && mt_pc[i] == m_cmp_pc) begin found = 1; d = mt_h[i]; end
            m_pass <= m_stall && found && d == m_cmp_h[HW-1:0];
            m_fail <= m_stall && !(found && d == m_cmp_h[HW-1:0]);
            if (m_stall && !(found && d == m_cmp_h[HW-1:0])) m_viol <= 1;
            m_stall <= 0;
            if (ret_valid && !m_stall) begin
                h0 = m_open ? m_h : SEED;
                p0 = m_open ? m_pc : ret_pc;
                hn = ref_step(h0, ret_instr);
                if (ref_end(ret_instr, ret_fn_last)) begin
                    m_stall <= 1; m_cmp_h <= hn; m_cmp_pc <= p0; m_open <= 0;
                end else begin
                    m_h <= hn; m_pc <= p0; m_open <= 1;
                end
            end
            if (tbl_we) begin
                mt_v[tbl_idx] <= 1; mt_pc[tbl_idx] <= tbl_pc; mt_h[tbl_idx] <= tbl_hash;
            end
        end
    end

    task automatic chk(string nm, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b", cur_req, nm, act, exp);
        end
    endtask

    // Compare all outputs against the reference on every falling edge.
    always @(negedge clk) begin
        if (chk_en && !done) begin
            chk("stall", stall, m_stall);
            chk("chk_pass", chk_pass, m_pass);
            chk("chk_fail", chk_fail, m_fail);
            chk("violation", violation, m_viol);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic send(logic [31:0] pc, logic [31:0] ins, bit fe);
        while (stall) @(negedge clk);
        ret_valid = 1; ret_pc = pc; ret_instr = ins; ret_fn_last = fe;
        @(negedge clk);
        ret_valid = 0; ret_fn_last = 0;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_tab(int idx, logic [31:0] pc, logic [HW-1:0] h);
        tbl_we = 1; tbl_idx = idx[3:0]; tbl_pc = pc; tbl_hash = h;
        @(negedge clk);
        tbl_we = 0;
    endtask

    task automatic run_blk(logic [31:0] pc0, int n, bit fe_last);
        for (int i = 0; i < n; i++) send(pc0 + 32'(4 * i), prog[i], fe_last && i == n - 1);
    endtask

    task automatic one(int idx, logic [31:0] pc, logic [31:0] ins);
        prog[0] = ins;
        wr_tab(idx, pc, blk_hash(1));
        run_blk(pc, 1, 0);
        idle(3);
    endtask

    // ---------------- watchdog ----------------
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // ---------------- test sequence ----------------
    initial begin
        logic [HW-1:0] h;
        idle(3);
        chk_en = 1;
        cur_req = "R1";
        chk("reset stall", stall, 0);
        chk("reset violation", violation, 0);
        rst_n = 1;
        idle(1);

        // R2 R5 R8: three-word block closed by beq, correct digest
        cur_req = "R8";
        prog[0] = I_ADDI; prog[1] = I_NOP; prog[2] = I_BEQ;
        wr_tab(0, 32'h100, blk_hash(3));
        run_blk(32'h100, 3, 0);
        // R7: junk jal offered during the stall cycle is ignored
        cur_req = "R7";
        ret_valid = 1; ret_pc = 32'h180; ret_instr = I_JAL;
        @(negedge clk);
        ret_valid = 0;
        idle(3);

        // R2: every ending encoding as a one-word block
        cur_req = "R2";
        one(1, 32'h400, I_BNE);
        one(2, 32'h408, I_BLT);
        one(3, 32'h410, I_BGE);
        one(4, 32'h418, I_BLTU);
        one(5, 32'h420, I_BGEU);
        one(6, 32'h428, I_JAL);
        one(7, 32'h430, I_JALR);
        one(8, 32'h438, I_RET);

        // R3: funct3 010/011 under branch opcode keep the block open
        cur_req = "R3";
        prog[0] = I_B010; prog[1] = I_LW; prog[2] = I_B011; prog[3] = I_JAL;
        wr_tab(9, 32'h500, blk_hash(4));
        run_blk(32'h500, 4, 0);
        idle(3);

        // R12: gaps of invalid cycles inside a block
        cur_req = "R12";
        prog[0] = I_ADDI; prog[1] = I_NOP; prog[2] = I_BGE;
        wr_tab(10, 32'h600, blk_hash(3));
        send(32'h600, I_ADDI, 0); idle(2);
        send(32'h604, I_NOP, 0); idle(1);
        send(32'h608, I_BGE, 0);
        idle(3);

        // R4: back-to-back blocks, second starts right after the first ends
        cur_req = "R4";
        prog[0] = I_NOP; prog[1] = I_BNE;
        wr_tab(11, 32'h700, blk_hash(2));
        prog[0] = I_LW; prog[1] = I_ADDI; prog[2] = I_RET;
        wr_tab(12, 32'h708, blk_hash(3));
        send(32'h700, I_NOP, 0); send(32'h704, I_BNE, 0);
        run_blk(32'h708, 3, 0);
        idle(3);

        // R2: function-boundary hint closes a block of plain instructions
        cur_req = "R2";
        prog[0] = I_ADDI; prog[1] = I_NOP;
        wr_tab(13, 32'h800, blk_hash(2));
        run_blk(32'h800, 2, 1);
        idle(3);

        // R11: duplicate address, lowest index holds the right digest
        cur_req = "R11";
        prog[0] = I_NOP; prog[1] = I_JAL;
        h = blk_hash(2);
        wr_tab(14, 32'h900, h ^ 16'h0001);
        wr_tab(4, 32'h900, h);
        run_blk(32'h900, 2, 0);
        idle(3);
        chk("violation after passes", violation, 0);

        // R9 R6: mismatch in the top compared bit
        cur_req = "R6";
        prog[0] = I_ADDI; prog[1] = I_BNE;
        wr_tab(15, 32'h200, blk_hash(2) ^ 16'h8000);
        run_blk(32'h200, 2, 0);
        idle(3);
        cur_req = "R9";
        chk("violation sticky", violation, 1);

        // R11: overwrite index 4 with a wrong digest; the lower entry now fails
        cur_req = "R11";
        prog[0] = I_NOP; prog[1] = I_JAL;
        wr_tab(4, 32'h900, blk_hash(2) ^ 16'h0100);
        run_blk(32'h900, 2, 0);
        idle(3);

        // R10: start address with no entry
        cur_req = "R10";
        prog[0] = I_LW; prog[1] = I_BLTU;
        run_blk(32'h300, 2, 0);
        idle(3);

        // R9: a later pass leaves violation high
        cur_req = "R9";
        prog[0] = I_ADDI; prog[1] = I_NOP; prog[2] = I_BEQ;
        run_blk(32'h100, 3, 0);
        idle(3);
        chk("violation held", violation, 1);

        // R1: reset clears the flag and the table
        cur_req = "R1";
        rst_n = 0; idle(2); rst_n = 1;
        chk("violation cleared", violation, 0);
        run_blk(32'h100, 3, 0);
        idle(3);
        chk("table cleared gives violation", violation, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule